// File: doc/BRIEF.md
# Z80 I/O Cycle Trap Controller

This block sits beside a Z80-style processor bus and produces the processor's clock. It samples the bus strobes, the low port address bits and the data bus through a two-stage synchronizer. From them it reports the kind of bus cycle in progress: port read, port write, interrupt acknowledge, memory read, memory write or none. Memory cycles and interrupt acknowledges pass through untouched. A port read or port write is trapped: the processor is stalled, and the port number, direction and write data go to a local service port as a request.

The stall takes one of two forms, picked by an input when the trap fires. In the first, the wait line is pulled low and the clock keeps running. In the second, the processor clock is frozen at its current level, which a static core tolerates for any length of time. The stall lasts until the service side answers with a done pulse. For a read, the returned byte is driven onto the data bus for a minimum setup window before the stall lifts.

To release, the wait line is forced inactive and the clock runs until the processor lifts the I/O strobe. Only then does the block stop driving the data bus and arm again. While nothing is trapped, the processor clock comes from a programmable divider of the system clock.

Top module: `iotrap_ctrl`

## Requirements
- R1: `cyc_kind` reports the synchronized bus as 0 none, 1 memory read (/RD low, /IORQ high), 2 memory write (/WR low, /IORQ high), 3 port read (/IORQ and /RD low), 4 port write (/IORQ and /WR low), 5 interrupt acknowledge (/IORQ and /M1 low, /RD and /WR high). /IORQ low with /RD, /WR and /M1 all high reports 0.
- R2: Memory cycles, interrupt acknowledges and idle bus never raise `svc_valid`, never lower `cpu_wait_n` and never stop `cpu_clk`.
- R3: When both the I/O strobe and a direction strobe are low at the pins, `svc_valid` rises after the third system clock edge and not after the second.
- R4: In wait mode (`stall_mode`=0, sampled when the trap fires), `cpu_wait_n` stays low for the whole stall while `cpu_clk` keeps toggling.
- R5: In clock-stop mode (`stall_mode`=1), `cpu_clk` holds its level through the stall and `cpu_wait_n` stays high.
- R6: During a stall, `svc_port`, `svc_write` (1 for a port write) and `svc_wdata` carry the trapped access. `svc_valid` stays high for as long as `svc_done` is absent and drops after the edge that samples `svc_done`.
- R7: On a read, the edge that samples `svc_done` captures `svc_rdata` onto `cpu_data_out` with `cpu_data_oe` high. The stall lifts SETUP_CYC edges after that edge and not earlier. A write lifts the stall at that same edge.
- R8: After the stall lifts, the clock runs and `cpu_wait_n` is high. `cpu_data_oe` stays high until the synchronized /IORQ is seen high, three edges after the pin rises, and no new request fires while /IORQ is still low.
- R9: Outside a clock-stop stall, `cpu_clk` toggles once every `clk_half_period` system clocks.
- R10: In reset, `cpu_clk` is 0, `cpu_wait_n` is 1, `cpu_data_oe` is 0, `svc_valid` is 0 and `cyc_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_mode | input | 1 | 0 stalls with the wait line, 1 freezes the processor clock |
| clk_half_period | input | DIV_W | System clocks per processor clock half-period |
| cpu_iorq_n | input | 1 | I/O request strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| cpu_port_addr | input | PORT_W | Low address bits used as port number |
| cpu_data_in | input | DATA_W | Data bus as driven by the processor |
| cpu_clk | output | 1 | Generated processor clock |
| cpu_wait_n | output | 1 | Wait request to the processor, active low |
| cpu_data_out | output | DATA_W | Read data to the data bus |
| cpu_data_oe | output | 1 | Drive enable for `cpu_data_out` |
| cyc_kind | output | 3 | Current bus cycle kind (R1 encoding) |
| svc_valid | output | 1 | Service request pending |
| svc_port | output | PORT_W | Trapped port number |
| svc_write | output | 1 | 1 for a port write |
| svc_wdata | output | DATA_W | Trapped write data |
| svc_rdata | input | DATA_W | Read data returned by the service side |
| svc_done | input | 1 | Service complete pulse |

## Verification
A table of strobe patterns is applied first: idle, opcode fetch, memory read, memory write, acknowledge, and a bare /IORQ with /M1 high. These separate the classification paths and show that none of them traps. Port reads and writes then run in both stall modes with distinct ports and data. Their timing is checked for trigger latency, wait-line versus frozen clock, the setup window after a read, and held data until /IORQ rises. The /IORQ line is kept low past the release to show that no second request fires. Divider ratios are changed to check the idle clock rate.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_MEMRD = 3'd1,
        K_MEMWR = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5
    } cyc_kind_t;

    typedef enum logic [1:0] {
        ST_ARMED,
        ST_SERVE,
        ST_SETUP,
        ST_RELEASE
    } trap_st_t;
endpackage

// File: rtl/iotrap_sync.sv
module iotrap_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                sync_q <= meta_q;
            end
        end
        assign q[i] = sync_q;
    end
endmodule

// File: rtl/iotrap_clkgen.sv
module iotrap_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             cpu_clk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gen_t;

    gen_t r_q, r_d;
    logic [DIV_W-1:0] limit;

    always_comb begin
        r_d   = r_q;
        limit = (half_period == '0) ? '0 : half_period - 1'b1;
        if (run) begin
            if (r_q.cnt >= limit) begin
                r_d.cnt = '0;
                r_d.lvl = ~r_q.lvl;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_clk = r_q.lvl;

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(r_q.cnt));
endmodule

// File: rtl/iotrap_fsm.sv
module iotrap_fsm
    import iotrap_pkg::*;
#(
    parameter int PORT_W    = 5,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_iorq_n,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic              s_m1_n,
    input  logic [PORT_W-1:0] s_port,
    input  logic [DATA_W-1:0] s_data,
    input  logic              stop_mode,
    input  logic              svc_done,
    input  logic [DATA_W-1:0] svc_rdata,
    output cyc_kind_t         kind,
    output logic              svc_valid,
    output logic [PORT_W-1:0] svc_port,
    output logic              svc_write,
    output logic [DATA_W-1:0] svc_wdata,
    output logic              wait_n,
    output logic              clk_run,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    localparam int CNT_W = $clog2(SETUP_CYC + 1);

    typedef struct packed {
        trap_st_t          st;
        cyc_kind_t         kind;
        logic [PORT_W-1:0] port;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [CNT_W-1:0]  cnt;
        logic              stop;
    } fsm_t;

    fsm_t r_q, r_d;
    cyc_kind_t kind_now;
    logic stalled;

    always_comb begin
        if (!s_iorq_n && !s_rd_n)                 kind_now = K_IORD;
        else if (!s_iorq_n && !s_wr_n)            kind_now = K_IOWR;
        else if (!s_iorq_n && !s_m1_n)            kind_now = K_INTA;
        else if (s_iorq_n && !s_rd_n)             kind_now = K_MEMRD;
        else if (s_iorq_n && !s_wr_n)             kind_now = K_MEMWR;
        else                                      kind_now = K_NONE;

        r_d      = r_q;
        r_d.kind = kind_now;
        case (r_q.st)
            ST_ARMED: begin
                if (kind_now == K_IORD || kind_now == K_IOWR) begin
                    r_d.st    = ST_SERVE;
                    r_d.port  = s_port;
                    r_d.write = (kind_now == K_IOWR);
                    r_d.wdata = s_data;
                    r_d.stop  = stop_mode;
                end
            end
            ST_SERVE: begin
                if (svc_done) begin
                    if (r_q.write) begin
                        r_d.st = ST_RELEASE;
                    end else begin
                        r_d.st    = ST_SETUP;
                        r_d.rdata = svc_rdata;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(SETUP_CYC - 1)) r_d.st  = ST_RELEASE;
                else                                  r_d.cnt = r_q.cnt + 1'b1;
            end
            default: begin
                if (s_iorq_n) r_d.st = ST_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_ARMED;
            r_q.kind  <= K_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign stalled   = (r_q.st == ST_SERVE) || (r_q.st == ST_SETUP);
    assign kind      = r_q.kind;
    assign svc_valid = (r_q.st == ST_SERVE);
    assign svc_port  = r_q.port;
    assign svc_write = r_q.write;
    assign svc_wdata = r_q.wdata;
    assign wait_n    = !(stalled && !r_q.stop);
    assign clk_run   = !(stalled && r_q.stop);
    assign data_oe   = !r_q.write && ((r_q.st == ST_SETUP) || (r_q.st == ST_RELEASE));
    assign data_out  = r_q.rdata;

    // R2: an acknowledge seen while armed leaves the trap armed
    a_r2_no_trap_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && kind_now == K_INTA) |=> svc_valid == 1'b0);

    a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !svc_done) |=> svc_valid);

    a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && $past(svc_valid)) |-> ($stable(svc_port) && $stable(svc_write) && $stable(svc_wdata)));

    a_r8_oe_until_iorq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> $past(s_iorq_n));
endmodule

// File: rtl/iotrap_ctrl.sv
module iotrap_ctrl
    import iotrap_pkg::*;
#(
    parameter int PORT_W    = 5,
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_mode,
    input  logic [DIV_W-1:0]  clk_half_period,
    input  logic              cpu_iorq_n,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic              cpu_m1_n,
    input  logic [PORT_W-1:0] cpu_port_addr,
    input  logic [DATA_W-1:0] cpu_data_in,
    output logic              cpu_clk,
    output logic              cpu_wait_n,
    output logic [DATA_W-1:0] cpu_data_out,
    output logic              cpu_data_oe,
    output logic [2:0]        cyc_kind,
    output logic              svc_valid,
    output logic [PORT_W-1:0] svc_port,
    output logic              svc_write,
    output logic [DATA_W-1:0] svc_wdata,
    input  logic [DATA_W-1:0] svc_rdata,
    input  logic              svc_done
);
    localparam int SYNC_W = 4 + PORT_W + DATA_W;

    logic [SYNC_W-1:0] bus_raw, bus_s;
    logic              s_iorq_n, s_rd_n, s_wr_n, s_m1_n;
    logic [PORT_W-1:0] s_port;
    logic [DATA_W-1:0] s_data;
    logic              clk_run;
    cyc_kind_t         kind;

    assign bus_raw = {cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_m1_n, cpu_port_addr, cpu_data_in};
    assign {s_iorq_n, s_rd_n, s_wr_n, s_m1_n, s_port, s_data} = bus_s;

    iotrap_sync #(
        .W      (SYNC_W),
        .RST_VAL({4'b1111, {(PORT_W + DATA_W){1'b0}}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (bus_raw),
        .q    (bus_s)
    );

    iotrap_fsm #(
        .PORT_W   (PORT_W),
        .DATA_W   (DATA_W),
        .SETUP_CYC(SETUP_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_iorq_n (s_iorq_n),
        .s_rd_n   (s_rd_n),
        .s_wr_n   (s_wr_n),
        .s_m1_n   (s_m1_n),
        .s_port   (s_port),
        .s_data   (s_data),
        .stop_mode(stall_mode),
        .svc_done (svc_done),
        .svc_rdata(svc_rdata),
        .kind     (kind),
        .svc_valid(svc_valid),
        .svc_port (svc_port),
        .svc_write(svc_write),
        .svc_wdata(svc_wdata),
        .wait_n   (cpu_wait_n),
        .clk_run  (clk_run),
        .data_oe  (cpu_data_oe),
        .data_out (cpu_data_out)
    );

    iotrap_clkgen #(
        .DIV_W(DIV_W)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (clk_run),
        .half_period(clk_half_period),
        .cpu_clk    (cpu_clk)
    );

    assign cyc_kind = kind;

    // R5: no processor clock edge while frozen
    a_r5_clock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_run && $past(!clk_run)) |-> $stable(cpu_clk));

    // R7: the stall never lifts while a request is still open
    a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wait_n) |-> !svc_valid);

    // R4: wait and clock freeze never coexist
    a_r4_one_stall_form: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cpu_wait_n && !clk_run));
endmodule

// File: tb/iotrap_ctrl_bench.sv
module iotrap_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP_CYC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall_mode = 1'b0;
    logic [7:0] clk_half_period = 8'd4;
    logic       cpu_iorq_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, cpu_m1_n = 1'b1;
    logic [4:0] cpu_port_addr = '0;
    logic [7:0] cpu_data_in = '0;
    logic       cpu_clk, cpu_wait_n, cpu_data_oe, svc_valid, svc_write;
    logic [7:0] cpu_data_out, svc_wdata;
    logic [2:0] cyc_kind;
    logic [4:0] svc_port;
    logic [7:0] svc_rdata = '0;
    logic       svc_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iotrap_ctrl #(.SETUP_CYC(SETUP_CYC)) u_iotrap_ctrl (
        .clk(clk), .rst_n(rst_n), .stall_mode(stall_mode), .clk_half_period(clk_half_period),
        .cpu_iorq_n(cpu_iorq_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n),
        .cpu_port_addr(cpu_port_addr), .cpu_data_in(cpu_data_in), .cpu_clk(cpu_clk),
        .cpu_wait_n(cpu_wait_n), .cpu_data_out(cpu_data_out), .cpu_data_oe(cpu_data_oe),
        .cyc_kind(cyc_kind), .svc_valid(svc_valid), .svc_port(svc_port), .svc_write(svc_write),
        .svc_wdata(svc_wdata), .svc_rdata(svc_rdata), .svc_done(svc_done)
    );

    // {iorq_n, rd_n, wr_n, m1_n, expected kind}
    localparam int NVEC = 6;
    localparam logic [6:0] VEC [NVEC] = '{
        {4'b1111, 3'd0},
        {4'b1010, 3'd1},
        {4'b1011, 3'd1},
        {4'b1101, 3'd2},
        {4'b0110, 3'd5},
        {4'b0111, 3'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_toggles(input int cycles, output int n);
        logic prev;
        n = 0;
        prev = cpu_clk;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cpu_clk != prev) n++;
            prev = cpu_clk;
        end
    endtask

    task automatic io_txn(input logic [4:0] port, input bit wr, input logic [7:0] wdata,
                          input logic [7:0] rdata, input bit stop);
        int   tog;
        logic clk0;
        @(negedge clk);
        stall_mode    = stop;
        cpu_port_addr = port;
        cpu_data_in   = wdata;
        cpu_iorq_n    = 1'b0;
        if (wr) cpu_wr_n = 1'b0; else cpu_rd_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(svc_valid == 1'b0, "R3 early", int'(svc_valid), 0);
        @(posedge clk); @(negedge clk);
        chk(svc_valid == 1'b1, "R3 trigger", int'(svc_valid), 1);
        chk(cyc_kind == (wr ? 3'd4 : 3'd3), "R1 io kind", int'(cyc_kind), wr ? 4 : 3);
        chk(svc_port == port, "R6 port", int'(svc_port), int'(port));
        chk(svc_write == wr, "R6 dir", int'(svc_write), int'(wr));
        if (wr) chk(svc_wdata == wdata, "R6 wdata", int'(svc_wdata), int'(wdata));
        clk0 = cpu_clk;
        count_toggles(24, tog);
        if (stop) begin
            chk(tog == 0, "R5 frozen", tog, 0);
            chk(cpu_wait_n == 1'b1, "R5 wait high", int'(cpu_wait_n), 1);
        end else begin
            chk(tog > 0, "R4 clock runs", tog, 1);
            chk(cpu_wait_n == 1'b0, "R4 wait low", int'(cpu_wait_n), 0);
        end
        chk(svc_valid == 1'b1, "R6 held", int'(svc_valid), 1);
        svc_done  = 1'b1;
        svc_rdata = rdata;
        @(posedge clk); @(negedge clk);
        svc_done = 1'b0;
        chk(svc_valid == 1'b0, "R6 drop", int'(svc_valid), 0);
        if (!wr) begin
            chk(cpu_data_oe == 1'b1 && cpu_data_out == rdata, "R7 data", int'(cpu_data_out), int'(rdata));
            repeat (SETUP_CYC - 1) @(posedge clk);
            @(negedge clk);
            chk(cpu_wait_n == stop, "R7 setup hold", int'(cpu_wait_n), int'(stop));
            if (stop) chk(cpu_clk == clk0, "R7 clock held", int'(cpu_clk), int'(clk0));
            @(posedge clk); @(negedge clk);
        end
        chk(cpu_wait_n == 1'b1, "R8 wait released", int'(cpu_wait_n), 1);
        @(posedge cpu_clk); @(posedge cpu_clk);
        repeat (10) @(negedge clk);
        chk(svc_valid == 1'b0, "R8 no rearm", int'(svc_valid), 0);
        if (!wr) chk(cpu_data_oe == 1'b1, "R8 oe held", int'(cpu_data_oe), 1);
        cpu_iorq_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        if (!wr) chk(cpu_data_oe == 1'b1, "R8 oe before sync", int'(cpu_data_oe), 1);
        @(posedge clk); @(negedge clk);
        chk(cpu_data_oe == 1'b0, "R8 oe off", int'(cpu_data_oe), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int tog;
        repeat (3) @(negedge clk);
        chk(cpu_clk == 1'b0 && cpu_wait_n == 1'b1 && cpu_data_oe == 1'b0, "R10 outputs",
            int'({cpu_clk, cpu_wait_n, cpu_data_oe}), 2);
        chk(svc_valid == 1'b0 && cyc_kind == 3'd0, "R10 request/kind", int'(cyc_kind), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            {cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_m1_n} = VEC[v][6:3];
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(cyc_kind == VEC[v][2:0], "R1 kind", int'(cyc_kind), int'(VEC[v][2:0]));
            count_toggles(12, tog);
            chk(svc_valid == 1'b0 && cpu_wait_n == 1'b1, "R2 no stall", int'(svc_valid), 0);
            chk(tog > 0, "R2 clock runs", tog, 1);
        end
        @(negedge clk);
        {cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_m1_n} = 4'b1111;
        repeat (4) @(negedge clk);

        io_txn(5'd17, 1'b0, 8'h00, 8'hA5, 1'b0);
        io_txn(5'd3,  1'b1, 8'h5C, 8'h00, 1'b0);
        io_txn(5'd31, 1'b0, 8'h00, 8'h3E, 1'b1);
        io_txn(5'd0,  1'b1, 8'hC7, 8'h00, 1'b1);

        clk_half_period = 8'd4;
        repeat (10) @(negedge clk);
        count_toggles(40, tog);
        chk(tog == 10, "R9 half 4", tog, 10);
        clk_half_period = 8'd2;
        repeat (10) @(negedge clk);
        count_toggles(40, tog);
        chk(tog == 20, "R9 half 2", tog, 20);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule